// File: doc/BRIEF.md
# Handshaked Signal Power Meter

This block estimates the mean power of a complex sample stream. For every accepted I/Q pair it adds I squared plus Q squared into a wide accumulator. It does this over an integration window whose length, counted in accepted words, is set by a static input. When a window closes, the upper bits of the sum become the window's result. The accumulator then starts the next window from zero.

Software gets a coherent reading through a one-shot handshake. Firing the armed one-shot opens the capture register and drops `stat_ready`. The next completed window is loaded into the capture register and raises `stat_ready`. The register then stays frozen until the one-shot is fired again, so the low and high halves always belong to one result. Two sticky flags report misuse. `stat_missed` shows that a window finished while an earlier reading was still unread. `stat_too_soon` shows that the one-shot was fired before a reading was available. A sync pulse abandons the current window, restarts the count, and presents a zero reading with `stat_ready` high so that software has a known starting point.

The sample input is a valid/ready stream. The meter never applies back-pressure. `samp_ready` stays high in every cycle after reset, and a word counts only in a cycle where `samp_valid` and `samp_ready` are both high. Control and status pins are plain levels or pulses.

Top module: `pwr_meter_hs`

## Requirements
- R1: `samp_ready` is low during reset and high in every cycle after it. A word is accepted only when `samp_valid` is high, and it contributes I*I + Q*Q, with `samp_i` and `samp_q` taken as 16-bit two's complement values.
- R2: A window holds `integ_len`+1 accepted words. Its result is bits 47:16 of the 48-bit sum of those words' contributions. The next window starts from a zero sum.
- R3: A `sync_in` pulse discards the partial window and restarts the word count. Within eight clocks it sets `stat_ready` and makes the captured value zero.
- R4: `fire` acts only if `arm` was pulsed in an earlier cycle and no effective fire has happened since then. An effective fire clears `stat_ready`, and a fire without a prior arm changes nothing.
- R5: A window that completes while `stat_ready` is low is loaded into the capture register, and `stat_ready` goes high.
- R6: While `stat_ready` is high, the captured value does not change until the next effective fire or sync. `pwr_hi` is bits 31:16 and `pwr_lo` is bits 15:0 of that one value.
- R7: A window that completes while `stat_ready` is high sets `stat_missed` and leaves the captured value unchanged.
- R8: An effective fire while `stat_ready` is low sets `stat_too_soon`. An effective fire while `stat_ready` is high leaves it clear.
- R9: An effective fire clears `stat_missed`.
- R10: After reset, `stat_ready`, `stat_missed`, `stat_too_soon`, `pwr_lo` and `pwr_hi` are all zero, and the one-shot is disarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| integ_len | input | 16 | Window length minus one, in accepted words |
| sync_in | input | 1 | Restart pulse for integration |
| samp_valid | input | 1 | Sample word present |
| samp_ready | output | 1 | Meter accepts samples (high after reset) |
| samp_i | input | 16 | In-phase sample, signed |
| samp_q | input | 16 | Quadrature sample, signed |
| arm | input | 1 | One-shot arm pulse |
| fire | input | 1 | One-shot fire pulse |
| pwr_lo | output | 16 | Captured power, low half |
| pwr_hi | output | 16 | Captured power, high half |
| stat_ready | output | 1 | A fresh reading is held |
| stat_missed | output | 1 | A window completed while a reading was unread |
| stat_too_soon | output | 1 | Last effective fire came before a reading was ready |

## Verification
The assertions watch the handshake on every cycle. They check that a sync raises ready on the next clock, that an effective fire drops ready and clears the missed flag, and that a held reading never moves. They also check that an unread completion raises missed without touching the capture, and that a fire while ready never sets too_soon. Only the bench scenarios can show that the captured numbers are right. It drives signed extremes, gaps in `samp_valid`, several window lengths and a sync in mid-window, and checks the resulting sums against values it computes itself. The same scenarios also show that an unarmed fire has no effect.

// File: rtl/pwr_meter_pkg.sv
package pwr_meter_pkg;
  localparam int unsigned DEF_SAMP_W = 16;
  localparam int unsigned DEF_CNT_W  = 16;
  localparam int unsigned DEF_ACC_W  = 48;
  localparam int unsigned DEF_RES_W  = 32;
endpackage

// File: rtl/pm_square.sv
module pm_square #(
  parameter int unsigned SAMP_W = 16,
  localparam int unsigned SQ_W  = 2 * SAMP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              in_take,
  input  logic [SAMP_W-1:0] in_i,
  input  logic [SAMP_W-1:0] in_q,
  output logic              sq_valid,
  output logic [SQ_W-1:0]   sq_val
);
  logic signed [SQ_W-1:0] prod_i;
  logic signed [SQ_W-1:0] prod_q;
  logic [SQ_W-1:0]        mag_sum;

  always_comb begin
    prod_i  = $signed(in_i) * $signed(in_i);
    prod_q  = $signed(in_q) * $signed(in_q);
    mag_sum = $unsigned(prod_i) + $unsigned(prod_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sq_valid <= 1'b0;
      sq_val   <= '0;
    end else if (flush) begin
      sq_valid <= 1'b0;
    end else begin
      sq_valid <= in_take;
      if (in_take) sq_val <= mag_sum;
    end
  end

  assert_take_propagates_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_take && !flush) |=> sq_valid);
endmodule

// File: rtl/pm_integrator.sv
module pm_integrator #(
  parameter int unsigned SQ_W  = 32,
  parameter int unsigned CNT_W = 16,
  parameter int unsigned ACC_W = 48,
  parameter int unsigned RES_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [CNT_W-1:0] win_last,
  input  logic             sq_valid,
  input  logic [SQ_W-1:0]  sq_val,
  output logic             win_done,
  output logic [RES_W-1:0] win_result
);
  localparam int unsigned PAD_W = ACC_W - SQ_W;

  logic [ACC_W-1:0] acc;
  logic [CNT_W-1:0] cnt;
  logic [ACC_W-1:0] acc_next;
  logic             is_last;

  always_comb begin
    acc_next = acc + {{PAD_W{1'b0}}, sq_val};
    is_last  = (cnt >= win_last);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc        <= '0;
      cnt        <= '0;
      win_done   <= 1'b0;
      win_result <= '0;
    end else if (restart) begin
      acc      <= '0;
      cnt      <= '0;
      win_done <= 1'b0;
    end else begin
      win_done <= 1'b0;
      if (sq_valid) begin
        if (is_last) begin
          win_done   <= 1'b1;
          win_result <= acc_next[ACC_W-1 -: RES_W];
          acc        <= '0;
          cnt        <= '0;
        end else begin
          acc <= acc_next;
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assert_window_fresh_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    win_done |-> (cnt == '0));
endmodule

// File: rtl/pm_handshake.sv
module pm_handshake #(
  parameter int unsigned RES_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_in,
  input  logic             arm,
  input  logic             fire,
  input  logic             win_done,
  input  logic [RES_W-1:0] win_result,
  output logic [RES_W-1:0] cap,
  output logic             ready,
  output logic             missed,
  output logic             too_soon
);
  logic armed;
  logic shot;
  logic open_now;

  always_comb begin
    shot     = fire && armed;
    open_now = !ready || shot;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else if (arm) armed <= 1'b1;
    else if (shot) armed <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap      <= '0;
      ready    <= 1'b0;
      missed   <= 1'b0;
      too_soon <= 1'b0;
    end else begin
      if (shot) begin
        too_soon <= !ready;
        missed   <= 1'b0;
      end
      if (sync_in) begin
        cap   <= '0;
        ready <= 1'b1;
      end else if (win_done) begin
        if (open_now) begin
          cap   <= win_result;
          ready <= 1'b1;
        end else begin
          missed <= 1'b1;
        end
      end else if (shot) begin
        ready <= 1'b0;
      end
    end
  end

  assert_sync_sets_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sync_in |=> (ready && cap == '0));
  assert_fire_drops_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (shot && !sync_in && !win_done) |=> !ready);
  assert_hold_reading_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !shot && !sync_in) |=> (ready && $stable(cap)));
  assert_missed_on_unread_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (win_done && ready && !shot && !sync_in) |=> (missed && $stable(cap)));
  assert_no_too_soon_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (shot && ready) |=> !too_soon);
  assert_fire_clears_missed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    shot |=> !missed);
endmodule

// File: rtl/pwr_meter_hs.sv
module pwr_meter_hs
  import pwr_meter_pkg::*;
#(
  parameter int unsigned SAMP_W = DEF_SAMP_W,
  parameter int unsigned CNT_W  = DEF_CNT_W,
  parameter int unsigned ACC_W  = DEF_ACC_W,
  parameter int unsigned RES_W  = DEF_RES_W,
  localparam int unsigned SQ_W   = 2 * SAMP_W,
  localparam int unsigned HALF_W = RES_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  integ_len,
  input  logic              sync_in,
  input  logic              samp_valid,
  output logic              samp_ready,
  input  logic [SAMP_W-1:0] samp_i,
  input  logic [SAMP_W-1:0] samp_q,
  input  logic              arm,
  input  logic              fire,
  output logic [HALF_W-1:0] pwr_lo,
  output logic [HALF_W-1:0] pwr_hi,
  output logic              stat_ready,
  output logic              stat_missed,
  output logic              stat_too_soon
);
  logic             up_q;
  logic             take;
  logic             sq_valid;
  logic [SQ_W-1:0]  sq_val;
  logic             win_done;
  logic [RES_W-1:0] win_result;
  logic [RES_W-1:0] cap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) up_q <= 1'b0;
    else        up_q <= 1'b1;
  end

  assign samp_ready = up_q;
  assign take       = samp_valid && samp_ready;

  pm_square #(.SAMP_W(SAMP_W)) u_sq (
    .clk(clk), .rst_n(rst_n), .flush(sync_in), .in_take(take),
    .in_i(samp_i), .in_q(samp_q), .sq_valid(sq_valid), .sq_val(sq_val)
  );

  pm_integrator #(.SQ_W(SQ_W), .CNT_W(CNT_W), .ACC_W(ACC_W), .RES_W(RES_W)) u_int (
    .clk(clk), .rst_n(rst_n), .restart(sync_in), .win_last(integ_len),
    .sq_valid(sq_valid), .sq_val(sq_val), .win_done(win_done), .win_result(win_result)
  );

  pm_handshake #(.RES_W(RES_W)) u_hs (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .arm(arm), .fire(fire),
    .win_done(win_done), .win_result(win_result), .cap(cap),
    .ready(stat_ready), .missed(stat_missed), .too_soon(stat_too_soon)
  );

  assign pwr_lo = cap[HALF_W-1:0];
  assign pwr_hi = cap[RES_W-1:HALF_W];

  assert_ready_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    up_q |=> samp_ready);
endmodule

// File: tb/sim_pwr_meter_hs.sv
module sim_pwr_meter_hs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] integ_len = 16'd3;
  logic        sync_in = 1'b0;
  logic        samp_valid = 1'b0;
  logic        samp_ready;
  logic [15:0] samp_i = '0;
  logic [15:0] samp_q = '0;
  logic        arm = 1'b0;
  logic        fire = 1'b0;
  logic [15:0] pwr_lo, pwr_hi;
  logic        stat_ready, stat_missed, stat_too_soon;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [31:0] expq[$];
  logic [47:0] model_acc;

  always #5 clk = ~clk;

  pwr_meter_hs u0 (
    .clk(clk), .rst_n(rst_n), .integ_len(integ_len), .sync_in(sync_in),
    .samp_valid(samp_valid), .samp_ready(samp_ready), .samp_i(samp_i), .samp_q(samp_q),
    .arm(arm), .fire(fire), .pwr_lo(pwr_lo), .pwr_hi(pwr_hi),
    .stat_ready(stat_ready), .stat_missed(stat_missed), .stat_too_soon(stat_too_soon)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: each rising edge of ready pops one expected reading
  logic prev_ready = 1'b0;
  always @(negedge clk) begin
    if (rst_n && stat_ready && !prev_ready) begin
      if (expq.size() == 0) chk("R5 unexpected reading", {pwr_hi, pwr_lo}, 32'hx);
      else chk("R2/R5/R6 reading", {pwr_hi, pwr_lo}, expq.pop_front());
    end
    prev_ready = stat_ready;
  end

  task automatic send(input logic signed [15:0] i, input logic signed [15:0] q, input int gap);
    longint si = i;
    longint sq = q;
    @(negedge clk);
    samp_valid = 1'b1; samp_i = i; samp_q = q;
    model_acc = model_acc + 48'(si * si + sq * sq);
    @(negedge clk);
    samp_valid = 1'b0; samp_i = 16'h7777; samp_q = 16'h7777;
    repeat (gap) @(negedge clk);
  endtask

  task automatic close_window();
    expq.push_back(model_acc[47:16]);
    model_acc = '0;
  endtask

  task automatic pulse_sync();
    @(negedge clk); sync_in = 1'b1;
    @(negedge clk); sync_in = 1'b0;
  endtask

  task automatic arm_fire();
    @(negedge clk); arm = 1'b1;
    @(negedge clk); arm = 1'b0; fire = 1'b1;
    @(negedge clk); fire = 1'b0;
  endtask

  task automatic wait_ready(input string req, input int limit);
    int n = 0;
    while (!stat_ready && n < limit) begin @(negedge clk); n++; end
    chk(req, {31'd0, stat_ready}, 32'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    model_acc = '0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 ready", {31'd0, stat_ready}, 0);
    chk("R10 missed", {31'd0, stat_missed}, 0);
    chk("R10 too_soon", {31'd0, stat_too_soon}, 0);
    chk("R10 power", {pwr_hi, pwr_lo}, 0);
    chk("R1 ready low in reset", {31'd0, samp_ready}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 samp_ready", {31'd0, samp_ready}, 1);

    // R3 sync gives zero reading within eight clocks
    expq.push_back(32'd0);
    pulse_sync();
    wait_ready("R3 ready after sync", 7);

    // R4 arm then fire clears ready; R8 no too_soon when ready
    arm_fire();
    chk("R4 ready cleared", {31'd0, stat_ready}, 0);
    chk("R8 too_soon clear on ready fire", {31'd0, stat_too_soon}, 0);

    // R1/R2 four words with valid gaps, large signed values
    send(-16'sd32768, -16'sd32768, 2);
    send(16'sd32767, 16'sd0, 0);
    send(-16'sd30000, 16'sd25000, 3);
    send(16'sd3, -16'sd4, 1);
    close_window();
    wait_ready("R5 ready after window", 20);

    // R7 missed: another window while ready, capture must hold
    held = {pwr_hi, pwr_lo};
    send(16'sd1000, 16'sd1000, 0);
    send(16'sd1000, 16'sd1000, 0);
    send(16'sd1000, 16'sd1000, 0);
    send(16'sd1000, 16'sd1000, 0);
    model_acc = '0;
    repeat (5) @(negedge clk);
    chk("R7 missed set", {31'd0, stat_missed}, 1);
    chk("R6/R7 capture held", {pwr_hi, pwr_lo}, held);

    // R4 fire without arm ignored
    @(negedge clk); fire = 1'b1;
    @(negedge clk); fire = 1'b0;
    @(negedge clk);
    chk("R4 unarmed fire keeps ready", {31'd0, stat_ready}, 1);
    chk("R4 unarmed fire keeps missed", {31'd0, stat_missed}, 1);

    // R9 effective fire clears missed
    arm_fire();
    chk("R9 missed cleared", {31'd0, stat_missed}, 0);
    chk("R4 ready cleared again", {31'd0, stat_ready}, 0);

    // R8 fire while not ready sets too_soon
    arm_fire();
    chk("R8 too_soon set", {31'd0, stat_too_soon}, 1);
    send(16'sd20000, -16'sd20000, 0);
    send(-16'sd12345, 16'sd32767, 1);
    send(16'sd0, 16'sd0, 0);
    send(16'sd32767, 16'sd32767, 0);
    close_window();
    wait_ready("R5 ready second window", 20);
    arm_fire();
    chk("R8 too_soon cleared by ready fire", {31'd0, stat_too_soon}, 0);

    // R3 sync mid-window discards partial sum
    send(16'sd30000, 16'sd30000, 0);
    send(16'sd30000, 16'sd30000, 0);
    model_acc = '0;
    expq.push_back(32'd0);
    pulse_sync();
    wait_ready("R3 ready after mid sync", 7);
    arm_fire();
    send(-16'sd32768, 16'sd32767, 0);
    send(16'sd100, 16'sd200, 0);
    send(-16'sd32768, 16'sd5, 0);
    send(16'sd17000, -16'sd9, 0);
    close_window();
    wait_ready("R2 window after sync", 20);

    // R2 single-word window
    integ_len = 16'd0;
    arm_fire();
    send(-16'sd32768, -16'sd32768, 0);
    close_window();
    wait_ready("R2 one-word window", 20);

    repeat (3) @(negedge clk);
    chk("R5 all readings seen", expq.size(), 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule